// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block carries 8-bit companded voice samples between a codec core and a serial PCM bus that many channels share. The bus bit clock arrives as a slow input that is synchronous to the system clock. The block finds its rising and falling edges and does all of its work on those edges. Transmit and receive each have their own frame sync and their own position counter, so the two frames can be offset from each other by any number of bit clocks.

Two frame-sync timings are supported. In aligned mode the slot starts on the same bit-clock rise at which the sync is first seen high. In delayed mode the slot starts one bit clock after that rise, and only in this mode do the programmed slot numbers take effect. On the assigned transmit slot, the block latches a byte from the core and shifts it out MSB first. During the same slot it asserts an active-low enable for an external backplane driver. On the assigned receive slot it shifts in a byte from the selected input. Single-cycle strobes tell the core when each slot has finished. A port select picks one of two transmit outputs and one of two receive inputs.

A power-down input silences the block. While it is high, the programmed slot numbers, mode and port select are left untouched.

Top module: `pcm_tsi`

## Requirements
- R1: After reset, both transmit output enables are low (high impedance), both driver enables are high, `tx_load` and `rx_done` are low, and `rx_byte` is 0.
- R2: When `delayed_mode`=0 (aligned), bit 0 of slot 0 occupies the bit-clock rise at which the frame sync is first sampled high, after being sampled low on the previous rise. The programmed slot number is ignored and slot 0 is always used.
- R3: When `delayed_mode`=1, slot 0 begins on the rise after the one at which the sync was sampled high. Assigned slot n (0 to 63) occupies bit-clock rises 8n to 8n+7, counted from that start.
- R4: The transmit and receive paths start from `tx_fs` and `rx_fs` respectively, and each uses its own slot number, so any skew between the two frames is honoured.
- R5: Transmit bits change only on bit-clock rises and are sent MSB first. The byte is taken from `tx_byte` at the rise of bit 0. Later changes to `tx_byte` have no effect on that slot.
- R6: The driver enable of the selected port goes low at the rise of bit 0 and returns high at the fall inside bit 7, which is 7.5 bit times in total. The other port's enable stays high.
- R7: Receive bits are sampled on bit-clock falls, MSB first, from the selected input, and the other input is ignored. `rx_byte` changes only when the eighth bit is taken.
- R8: `port_sel`=0 uses `dx0`, `dx0_oe`, `dx_en0_n` and `dr0`, and `port_sel`=1 uses the port-1 set. The unselected transmit output enable stays low.
- R9: Outside the assigned transmit slot, both transmit output enables are low.
- R10: `tx_load` is a one-cycle pulse on the bit-clock rise that follows the last transmit bit. `rx_done` is a one-cycle pulse, raised together with the new `rx_byte`, after the last receive bit has been sampled.
- R11: A frame sync that arrives during a slot restarts that direction's counting from the new sync. The interrupted slot produces no strobe.
- R12: While `pdn` is high, both output enables are low, both driver enables are high, syncs are ignored, no strobes occur, and `rx_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk |
| pdn | input | 1 | Power-down |
| delayed_mode | input | 1 | 0 aligned sync, 1 delayed sync with slot assignment |
| port_sel | input | 1 | Selects port 0 or port 1 |
| tx_fs | input | 1 | Transmit frame sync |
| rx_fs | input | 1 | Receive frame sync |
| tx_slot | input | 6 | Assigned transmit slot |
| rx_slot | input | 6 | Assigned receive slot |
| tx_byte | input | 8 | Sample from the encoder |
| tx_load | output | 1 | Pulse after the transmit slot |
| dx0 | output | 1 | Port-0 transmit data |
| dx0_oe | output | 1 | Port-0 transmit output enable (low = high impedance) |
| dx1 | output | 1 | Port-1 transmit data |
| dx1_oe | output | 1 | Port-1 transmit output enable |
| dx_en0_n | output | 1 | Port-0 backplane driver enable, active low |
| dx_en1_n | output | 1 | Port-1 backplane driver enable, active low |
| dr0 | input | 1 | Port-0 receive data |
| dr1 | input | 1 | Port-1 receive data |
| rx_byte | output | 8 | Last received sample |
| rx_done | output | 1 | Pulse when a receive slot completes |

## Verification
The hardest cases to reach are a frame sync that lands in the middle of an assigned slot, and slot 63 at the very end of a 512-bit frame. The stimulus schedules a second sync a few bits into a running slot on both directions at once. It then checks that the cut-off slot raises no strobe and that the restarted slot delivers the full byte. A separate frame assigns slot 63 and runs more than 520 bit clocks, so the counter reaches its largest value. A behavioural model in the bench predicts every output for each bit-clock phase from the sync times it scheduled.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;

    localparam int BYTE_W = 8;
    localparam int IDX_W  = 3;

    typedef enum logic {
        FS_ALIGNED = 1'b0,
        FS_DELAYED = 1'b1
    } fs_mode_e;

    // Event produced by a slot timer on a bit-clock rise
    typedef struct packed {
        logic             bit_on;    // a slot bit starts on this rise
        logic [IDX_W-1:0] idx;       // bit number inside the slot
        logic             slot_end;  // rise following the last bit
    } slot_evt_t;

    // MSB-first bit position for slot bit i
    function automatic logic [IDX_W-1:0] msb_first(input logic [IDX_W-1:0] i);
        return IDX_W'(BYTE_W - 1) - i;
    endfunction

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
    import pcm_tsi_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn,
    input  logic              rise,
    input  logic              fs,
    input  fs_mode_e          mode,
    input  logic [SLOT_W-1:0] slot,
    output slot_evt_t         evt
);
    localparam int POS_W = SLOT_W + IDX_W + 1;

    logic             fs_prev;
    logic             armed, running;
    logic [POS_W-1:0] pos;
    logic             nxt_arm, nxt_run;
    logic [POS_W-1:0] nxt_pos;
    logic [SLOT_W-1:0] tgt;
    logic [POS_W-1:0] first_pos, end_pos;
    logic             sync;

    assign sync      = rise & fs & ~fs_prev;
    assign tgt       = (mode == FS_DELAYED) ? slot : '0;
    assign first_pos = POS_W'({tgt, 3'b000});
    assign end_pos   = first_pos + POS_W'(BYTE_W);

    always_comb begin
        nxt_arm = armed;
        nxt_run = running;
        nxt_pos = pos;
        if (pdn) begin
            nxt_arm = 1'b0;
            nxt_run = 1'b0;
            nxt_pos = '0;
        end else if (rise) begin
            if (sync) begin
                if (mode == FS_DELAYED) begin
                    nxt_arm = 1'b1;
                    nxt_run = 1'b0;
                end else begin
                    nxt_arm = 1'b0;
                    nxt_run = 1'b1;
                    nxt_pos = '0;
                end
            end else if (armed) begin
                nxt_arm = 1'b0;
                nxt_run = 1'b1;
                nxt_pos = '0;
            end else if (running) begin
                if (pos >= end_pos) nxt_run = 1'b0;
                else                nxt_pos = pos + 1'b1;
            end
        end
    end

    always_comb begin
        evt.bit_on   = rise & ~pdn & nxt_run & (nxt_pos >= first_pos) & (nxt_pos < end_pos);
        evt.idx      = nxt_pos[IDX_W-1:0];
        evt.slot_end = rise & ~pdn & nxt_run & (nxt_pos == end_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev <= 1'b0;
            armed   <= 1'b0;
            running <= 1'b0;
            pos     <= '0;
        end else begin
            if (rise) fs_prev <= fs;
            armed   <= nxt_arm;
            running <= nxt_run;
            pos     <= nxt_pos;
        end
    end

    a_r3_arm_excl: assert property (@(posedge clk) disable iff (rst)
        !(armed && running));

    a_r11_sync_restarts: assert property (@(posedge clk) disable iff (rst)
        (rise && sync && !pdn && mode == FS_ALIGNED) |=> (running && pos == '0));

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
    import pcm_tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn,
    input  logic              rise,
    input  logic              fall,
    input  slot_evt_t         evt,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              drive_on,
    output logic              drive_bit,
    output logic              en_on,
    output logic              load_pulse
);
    logic [BYTE_W-1:0] hold;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold       <= '0;
            idx_q      <= '0;
            drive_on   <= 1'b0;
            drive_bit  <= 1'b0;
            en_on      <= 1'b0;
            load_pulse <= 1'b0;
        end else begin
            load_pulse <= evt.slot_end & ~pdn;
            if (pdn) begin
                drive_on <= 1'b0;
                en_on    <= 1'b0;
            end else if (rise) begin
                if (evt.bit_on) begin
                    drive_on <= 1'b1;
                    en_on    <= 1'b1;
                    idx_q    <= evt.idx;
                    if (evt.idx == '0) begin
                        hold      <= tx_byte;
                        drive_bit <= tx_byte[BYTE_W-1];
                    end else begin
                        drive_bit <= hold[msb_first(evt.idx)];
                    end
                end else begin
                    drive_on <= 1'b0;
                    en_on    <= 1'b0;
                end
            end else if (fall && en_on && idx_q == IDX_W'(BYTE_W - 1)) begin
                en_on <= 1'b0;
            end
        end
    end

    a_r6_en_within_drive: assert property (@(posedge clk) disable iff (rst)
        en_on |-> drive_on);

    a_r5_tx_changes_on_rise: assert property (@(posedge clk) disable iff (rst)
        (drive_bit != $past(drive_bit)) |-> $past(rise));

endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter
    import pcm_tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pdn,
    input  logic              rise,
    input  logic              fall,
    input  slot_evt_t         evt,
    input  logic              din,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_done
);
    logic              act;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            act     <= 1'b0;
            idx_q   <= '0;
            sr      <= '0;
            rx_byte <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (pdn) begin
                act <= 1'b0;
            end else if (rise) begin
                act   <= evt.bit_on;
                idx_q <= evt.idx;
            end else if (fall && act) begin
                sr <= {sr[BYTE_W-2:0], din};
                if (idx_q == IDX_W'(BYTE_W - 1)) begin
                    rx_byte <= {sr[BYTE_W-2:0], din};
                    rx_done <= 1'b1;
                end
            end
        end
    end

    a_r7_rx_update_on_fall: assert property (@(posedge clk) disable iff (rst)
        (rx_byte != $past(rx_byte)) |-> $past(fall));

endmodule

// File: rtl/pcm_tsi.sv
module pcm_tsi
    import pcm_tsi_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk,
    input  logic              pdn,
    input  logic              delayed_mode,
    input  logic              port_sel,
    input  logic              tx_fs,
    input  logic              rx_fs,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [7:0]        tx_byte,
    output logic              tx_load,
    output logic              dx0,
    output logic              dx0_oe,
    output logic              dx1,
    output logic              dx1_oe,
    output logic              dx_en0_n,
    output logic              dx_en1_n,
    input  logic              dr0,
    input  logic              dr1,
    output logic [7:0]        rx_byte,
    output logic              rx_done
);
    logic      bclk_q;
    logic      rise, fall;
    fs_mode_e  mode;
    slot_evt_t tx_evt, rx_evt;
    logic      drive_on, drive_bit, en_on;
    logic      din;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    assign rise = bclk & ~bclk_q;
    assign fall = ~bclk & bclk_q;
    assign mode = fs_mode_e'(delayed_mode);

    pcm_slot_timer #(.SLOT_W(SLOT_W)) u_tx_timer (
        .clk(clk), .rst(rst), .pdn(pdn), .rise(rise), .fs(tx_fs),
        .mode(mode), .slot(tx_slot), .evt(tx_evt)
    );

    pcm_slot_timer #(.SLOT_W(SLOT_W)) u_rx_timer (
        .clk(clk), .rst(rst), .pdn(pdn), .rise(rise), .fs(rx_fs),
        .mode(mode), .slot(rx_slot), .evt(rx_evt)
    );

    pcm_tx_shifter u_tx (
        .clk(clk), .rst(rst), .pdn(pdn), .rise(rise), .fall(fall),
        .evt(tx_evt), .tx_byte(tx_byte), .drive_on(drive_on),
        .drive_bit(drive_bit), .en_on(en_on), .load_pulse(tx_load)
    );

    assign din = port_sel ? dr1 : dr0;

    pcm_rx_shifter u_rx (
        .clk(clk), .rst(rst), .pdn(pdn), .rise(rise), .fall(fall),
        .evt(rx_evt), .din(din), .rx_byte(rx_byte), .rx_done(rx_done)
    );

    assign dx0_oe   = drive_on & ~pdn & ~port_sel;
    assign dx1_oe   = drive_on & ~pdn &  port_sel;
    assign dx0      = drive_bit & dx0_oe;
    assign dx1      = drive_bit & dx1_oe;
    assign dx_en0_n = ~(en_on & ~pdn & ~port_sel);
    assign dx_en1_n = ~(en_on & ~pdn &  port_sel);

    a_r10_load_single: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    a_r12_pdn_quiet: assert property (@(posedge clk) disable iff (rst)
        (pdn && $past(pdn)) |-> (!tx_load && !rx_done && $stable(rx_byte)));

endmodule

// File: tb/sim_pcm_tsi.sv
module sim_pcm_tsi;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst, bclk, pdn, delayed_mode, port_sel, tx_fs, rx_fs;
    logic [5:0] tx_slot, rx_slot;
    logic [7:0] tx_byte, rx_byte;
    logic       tx_load, dx0, dx0_oe, dx1, dx1_oe, dx_en0_n, dx_en1_n;
    logic       dr0, dr1, rx_done;

    always #2 clk = ~clk;

    pcm_tsi u0 (
        .clk(clk), .rst(rst), .bclk(bclk), .pdn(pdn), .delayed_mode(delayed_mode),
        .port_sel(port_sel), .tx_fs(tx_fs), .rx_fs(rx_fs), .tx_slot(tx_slot),
        .rx_slot(rx_slot), .tx_byte(tx_byte), .tx_load(tx_load), .dx0(dx0),
        .dx0_oe(dx0_oe), .dx1(dx1), .dx1_oe(dx1_oe), .dx_en0_n(dx_en0_n),
        .dx_en1_n(dx_en1_n), .dr0(dr0), .dr1(dr1), .rx_byte(rx_byte), .rx_done(rx_done)
    );

    int checks = 0, errors = 0;
    int n_load = 0, n_done = 0;
    int exp_load = 0, exp_done = 0;
    int rise_n = 0;
    int tx_start = -100000, rx_start = -100000;
    int cur_tp = -100, cur_rp = -100;
    int tx_syncs[$], rx_syncs[$];
    logic [7:0] exp_tx, exp_rx, rx_send;
    string scen = "R1";
    bit finished = 0;

    always @(posedge clk) begin
        if (!rst) begin
            if (tx_load) n_load++;
            if (rx_done) n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", req, scen, act, exp);
        end
    endtask

    function automatic bit in_q(input int q[$], input int v);
        foreach (q[i]) if (q[i] == v) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check_outputs(input bit high);
        bit act;
        bit e_oe0, e_oe1, e_en0, e_en1;
        act   = !pdn && cur_tp >= 0 && cur_tp < 8;
        e_oe0 = act && !port_sel;
        e_oe1 = act && port_sel;
        e_en0 = !(e_oe0 && !(!high && cur_tp == 7));
        e_en1 = !(e_oe1 && !(!high && cur_tp == 7));
        chk(dx0_oe == e_oe0, "R8 R9 dx0_oe", dx0_oe, e_oe0);
        chk(dx1_oe == e_oe1, "R8 R9 dx1_oe", dx1_oe, e_oe1);
        chk(dx_en0_n == e_en0, "R6 dx_en0_n", dx_en0_n, e_en0);
        chk(dx_en1_n == e_en1, "R6 dx_en1_n", dx_en1_n, e_en1);
        if (act) begin
            chk((port_sel ? dx1 : dx0) == exp_tx[7-cur_tp], "R5 tx bit",
                port_sel ? dx1 : dx0, exp_tx[7-cur_tp]);
        end
        chk(n_load == exp_load, "R10 tx_load count", n_load, exp_load);
        chk(n_done == exp_done, "R10 rx_done count", n_done, exp_done);
        chk(rx_byte == exp_rx, "R7 rx_byte", rx_byte, exp_rx);
    endtask

    task automatic bit_period();
        int ttgt, rtgt, rp;
        bit bv;
        @(negedge clk);
        rise_n++;
        bclk = 1'b1;
        if (!pdn && in_q(tx_syncs, rise_n)) tx_start = rise_n + (delayed_mode ? 1 : 0);
        if (!pdn && in_q(rx_syncs, rise_n)) rx_start = rise_n + (delayed_mode ? 1 : 0);
        ttgt   = delayed_mode ? int'(tx_slot) : 0;
        rtgt   = delayed_mode ? int'(rx_slot) : 0;
        cur_tp = rise_n - tx_start - ttgt * 8;
        rp     = rise_n - rx_start - rtgt * 8;
        cur_rp = rp;
        if (!pdn && cur_tp == 0) exp_tx = tx_byte;
        if (!pdn && cur_tp == 8) exp_load++;
        if (!pdn && rp >= 0 && rp < 8) begin
            bv  = rx_send[7-rp];
            dr0 = port_sel ? ~bv : bv;
            dr1 = port_sel ? bv : ~bv;
        end else begin
            dr0 = rise_n[0];
            dr1 = ~rise_n[0];
        end
        repeat (H - 1) @(negedge clk);
        check_outputs(1'b1);
        @(negedge clk);
        bclk = 1'b0;
        if (!pdn && cur_rp == 7) begin
            exp_done++;
            exp_rx = rx_send;
        end
        tx_fs = in_q(tx_syncs, rise_n + 1);
        rx_fs = in_q(rx_syncs, rise_n + 1);
        repeat (H - 1) @(negedge clk);
        check_outputs(1'b0);
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) bit_period();
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bclk = 1'b0; pdn = 1'b0; delayed_mode = 1'b0; port_sel = 1'b0;
        tx_fs = 1'b0; rx_fs = 1'b0; tx_slot = '0; rx_slot = '0; tx_byte = '0;
        dr0 = 1'b0; dr1 = 1'b0; exp_tx = '0; exp_rx = '0; rx_send = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_outputs(1'b0);
        chk(tx_load == 1'b0 && rx_done == 1'b0, "R1 strobes", tx_load, 0);

        // R2: aligned sync, programmed slots ignored
        scen = "R2"; tx_slot = 6'd5; rx_slot = 6'd9; tx_byte = 8'hA5; rx_send = 8'h3C;
        tx_syncs = {rise_n + 3}; rx_syncs = {rise_n + 3};
        run_bits(20);

        // R3 R4 R5: delayed mode, skewed frames, port 1, tx_byte changed mid-slot
        scen = "R3 R4 R5"; delayed_mode = 1'b1; port_sel = 1'b1;
        tx_slot = 6'd3; rx_slot = 6'd7; tx_byte = 8'h5A; rx_send = 8'hC3;
        tx_syncs = {rise_n + 2}; rx_syncs = {rise_n + 7};
        run_bits(30);
        tx_byte = 8'hFF;
        run_bits(40);

        // R3: last slot of the frame
        scen = "R3 slot63"; port_sel = 1'b0; tx_slot = 6'd63; rx_slot = 6'd63;
        tx_byte = 8'h81; rx_send = 8'h7E;
        tx_syncs = {rise_n + 2}; rx_syncs = {rise_n + 2};
        run_bits(530);

        // R11: second sync inside a running slot restarts both directions
        scen = "R11"; tx_slot = 6'd1; rx_slot = 6'd1; tx_byte = 8'h96; rx_send = 8'h69;
        tx_syncs = {rise_n + 2, rise_n + 14}; rx_syncs = {rise_n + 2, rise_n + 14};
        run_bits(40);

        // R12: power-down ignores syncs and keeps everything quiet
        scen = "R12"; pdn = 1'b1; delayed_mode = 1'b0; tx_byte = 8'h11; rx_send = 8'hEE;
        tx_syncs = {rise_n + 2}; rx_syncs = {rise_n + 2};
        run_bits(20);
        pdn = 1'b0;
        run_bits(4);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule